// File: doc/BRIEF.md
# Multi-Lane Receive Deskew Controller

This block removes arrival skew between up to four serial-link receive lanes. Each lane arrives already decoded: one byte per clock, a flag that marks the byte as a control character, and a locked indication from upstream. Every lane passes through its own tapped delay line of up to 15 cycles. The block looks for alignment markers on each lane. A marker is the control character 0x7C with the control flag set. The block then picks the taps so that one marker set leaves every lane of a group on the same cycle.

A small register bank sets the behaviour. It chooses whether all four lanes form one group or lanes 1:0 and 3:2 form two groups. It also sets how many complete marker sets must arrive before the delays are loaded, and which lane-lock condition lets the search begin. Instead of the search, a fixed per-lane delay can be loaded from the manual registers. Once a group is aligned, its output markers are watched. If they stop arriving together, a misalignment flag is raised, and the search can optionally restart.

Top module: `lane_deskew`

## Requirements
- R1: The register bank has these fields. Address 07h: bit 0 enable, bit 1 four-lane grouping, bits 3:2 marker-set count code, bits 6:4 start code. Address 08h: bit 0 manual delays, bit 1 dynamic re-alignment. Address 09h: lane 0 delay in bits 3:0, lane 1 delay in bits 7:4. Address 0Ah: lane 2 delay in bits 3:0, lane 3 delay in bits 7:4. All registers reset to 00h, a write on `cfg_we` takes effect at the clock edge, `cfg_rdata` returns the addressed register combinationally, and any other address reads 00h.
- R2: While the enable bit is 0, every lane reaches its output with no delay in the same cycle, and both status vectors and the skew error read 0 from the next cycle on.
- R3: In automatic mode the last-arriving lane of a complete set gets delay 1. Every other lane gets 1 plus the number of cycles by which its marker came earlier. The markers of the set that loads the delays leave all lanes of the group on the cycle after the last marker arrived, and the group's aligned bit rises on that same cycle.
- R4: Only a byte of 0x7C with its control flag set counts as a marker. The same byte without the flag is ordinary data.
- R5: Count code n (0..3) loads the delays on the (n+1)-th complete marker set. Earlier sets leave the delays unchanged.
- R6: Start code 0 waits for every lane of the group to be locked. Code 1 waits for any lane of the group. Codes 2, 3, 4 and 5 each wait for lane 0, 1, 2 or 3 respectively. Markers seen before the condition holds are ignored.
- R7: With the grouping bit at 0, lanes 1:0 and lanes 3:2 are aligned independently, and `grp_aligned` bits 0 and 1 report the two pairs. With it at 1, both bits report the single four-lane group.
- R8: All markers of a set must fall within offsets 0 to 14 of the first one. A skew of 14 cycles aligns. A skew of 15 sets `skew_err`, discards the partial count and keeps the present delays. A later load clears `skew_err`.
- R9: With the manual bit at 1 (and enable at 1), each lane's delay is its 4-bit manual field, and the aligned bits stay 0.
- R10: When an aligned group outputs a marker on some but not all of its lanes, its `grp_misalign` bit goes to 1. With dynamic re-alignment at 0, the delays and the aligned bit stay as they were.
- R11: With dynamic re-alignment at 1, a misalignment clears the aligned bit and restarts marker counting. The next load sets new delays and clears `grp_misalign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Register address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| rx_data | input | 32 | Received bytes, lane i in bits 8i+7:8i |
| rx_ctrl | input | 4 | Control-character flag per lane |
| rx_lock | input | 4 | Lane-locked indication per lane |
| tx_data | output | 32 | Deskewed bytes, same layout as rx_data |
| tx_ctrl | output | 4 | Deskewed control flags |
| grp_aligned | output | 2 | Aligned status per group |
| grp_misalign | output | 2 | Misalignment seen per group |
| skew_err | output | 1 | Marker set spread beyond the window |

## Verification
The main function is driven with marker sets of distinct skew shapes. Shapes where the last lane differs between sets show whether the delay is keyed to the latest arrival rather than to a fixed lane. Pairs skewed by different amounts separate pair grouping from four-lane grouping, because the two give different exit cycles. Skews of exactly 14 and 15 cycles pin the window edge. A flagless 0x7C on one lane tests that a marker needs its control flag. Equal-arrival sets sent after alignment expose the stored delays at the outputs, which shows whether an error, a partial count or a monitoring event changed them.

// File: rtl/lane_deskew.sv
module lane_deskew #(
  parameter int DW = 8,
  parameter int DEPTH = 15,
  parameter logic [7:0] MARKER = 8'h7C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_addr,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic [4*DW-1:0] rx_data,
  input  logic [3:0]    rx_ctrl,
  input  logic [3:0]    rx_lock,
  output logic [4*DW-1:0] tx_data,
  output logic [3:0]    tx_ctrl,
  output logic [1:0]    grp_aligned,
  output logic [1:0]    grp_misalign,
  output logic          skew_err
);
  localparam int NL = 4;
  localparam int NG = 2;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_CNT = 2'd1, S_MON = 2'd2;

  logic [7:0] r_ctrl, r_mode, r_man01, r_man23;
  logic en, grp4, manual, dyn;
  logic [1:0] trig;
  logic [2:0] start;

  assign en     = r_ctrl[0];
  assign grp4   = r_ctrl[1];
  assign trig   = r_ctrl[3:2];
  assign start  = r_ctrl[6:4];
  assign manual = r_mode[0];
  assign dyn    = r_mode[1];

  logic unused_cfg;
  assign unused_cfg = ^{r_ctrl[7], r_mode[7:2]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_ctrl <= '0; r_mode <= '0; r_man01 <= '0; r_man23 <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        8'h07: r_ctrl  <= cfg_wdata;
        8'h08: r_mode  <= cfg_wdata;
        8'h09: r_man01 <= cfg_wdata;
        8'h0A: r_man23 <= cfg_wdata;
        default: ;
      endcase
    end

  always_comb
    case (cfg_addr)
      8'h07:   cfg_rdata = r_ctrl;
      8'h08:   cfg_rdata = r_mode;
      8'h09:   cfg_rdata = r_man01;
      8'h0A:   cfg_rdata = r_man23;
      default: cfg_rdata = '0;
    endcase

  logic [LW-1:0] man_d [NL];
  assign man_d[0] = LW'(r_man01[3:0]);
  assign man_d[1] = LW'(r_man01[7:4]);
  assign man_d[2] = LW'(r_man23[3:0]);
  assign man_d[3] = LW'(r_man23[7:4]);

  logic [LW-1:0] adly [NL];
  logic [LW-1:0] eff  [NL];
  logic [NL-1:0] mk, omk;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [DW:0] pipe [DEPTH];
    logic [DW:0] tap;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        for (int j = 0; j < DEPTH; j++) pipe[j] <= '0;
      end else begin
        pipe[0] <= {rx_ctrl[i], rx_data[i*DW +: DW]};
        for (int j = 1; j < DEPTH; j++) pipe[j] <= pipe[j-1];
      end

    assign eff[i] = !en ? '0 : (manual ? man_d[i] : adly[i]);
    assign tap = (eff[i] == '0) ? {rx_ctrl[i], rx_data[i*DW +: DW]} : pipe[eff[i] - 1'b1];
    assign tx_ctrl[i] = tap[DW];
    assign tx_data[i*DW +: DW] = tap[DW-1:0];
    assign mk[i]  = rx_ctrl[i] && (rx_data[i*DW +: DW] == MARKER[DW-1:0]);
    assign omk[i] = tap[DW] && (tap[DW-1:0] == MARKER[DW-1:0]);
  end

  logic [1:0]    st   [NG];
  logic [1:0]    cnt  [NG];
  logic [LW-1:0] wcnt [NG];
  logic [NL-1:0] seen [NG];
  logic [LW-1:0] tarr [NL];
  logic [NG-1:0] pend, al, mis;
  logic          err;

  logic [NL-1:0] gm [NG], hit [NG], snext [NG];
  logic [LW-1:0] cur [NG];
  logic [LW-1:0] newd [NL];
  logic [NG-1:0] act, go, done, expire, apply, omis;

  function automatic logic [LW-1:0] dcalc(input logic s, input logic [LW-1:0] t,
                                          input logic [LW-1:0] c);
    return LW'(1) + c - (s ? t : c);
  endfunction

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      gm[g]  = (g == 0) ? (grp4 ? 4'hF : 4'h3) : 4'hC;
      act[g] = en && !manual && (g == 0 || !grp4);
      case (start)
        3'd1:    go[g] = |(rx_lock & gm[g]);
        3'd2:    go[g] = rx_lock[0];
        3'd3:    go[g] = rx_lock[1];
        3'd4:    go[g] = rx_lock[2];
        3'd5:    go[g] = rx_lock[3];
        default: go[g] = (rx_lock & gm[g]) == gm[g];
      endcase
      hit[g]    = mk & gm[g];
      cur[g]    = pend[g] ? wcnt[g] : '0;
      snext[g]  = seen[g] | hit[g];
      done[g]   = st[g] == S_CNT && (pend[g] || |hit[g]) && (snext[g] & gm[g]) == gm[g];
      expire[g] = st[g] == S_CNT && pend[g] && !done[g] && wcnt[g] == LW'(DEPTH - 1);
      apply[g]  = done[g] && cnt[g] == trig;
      omis[g]   = st[g] == S_MON && |(omk & gm[g]) && (omk & gm[g]) != gm[g];
    end
    for (int i = 0; i < NL; i++)
      newd[i] = (grp4 || i < 2) ? dcalc(seen[0][i], tarr[i], cur[0])
                                : dcalc(seen[1][i], tarr[i], cur[1]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin
        st[g] <= S_IDLE; cnt[g] <= '0; wcnt[g] <= '0; seen[g] <= '0;
      end
      for (int i = 0; i < NL; i++) begin
        tarr[i] <= '0; adly[i] <= '0;
      end
      pend <= '0; al <= '0; mis <= '0; err <= 1'b0;
    end else begin
      if (!en) begin
        for (int i = 0; i < NL; i++) adly[i] <= '0;
        err <= 1'b0;
      end
      for (int g = 0; g < NG; g++) begin
        if (!act[g]) begin
          st[g] <= S_IDLE; cnt[g] <= '0; seen[g] <= '0;
          pend[g] <= 1'b0; al[g] <= 1'b0; mis[g] <= 1'b0;
        end else begin
          case (st[g])
            S_IDLE: if (go[g]) st[g] <= S_CNT;
            S_CNT: begin
              if (done[g]) begin
                pend[g] <= 1'b0;
                seen[g] <= '0;
                if (apply[g]) begin
                  for (int i = 0; i < NL; i++)
                    if (gm[g][i]) adly[i] <= newd[i];
                  st[g] <= S_MON; al[g] <= 1'b1; mis[g] <= 1'b0;
                  cnt[g] <= '0; err <= 1'b0;
                end else begin
                  cnt[g] <= cnt[g] + 1'b1;
                end
              end else if (expire[g]) begin
                pend[g] <= 1'b0; seen[g] <= '0; cnt[g] <= '0; err <= 1'b1;
              end else if (pend[g] || |hit[g]) begin
                pend[g] <= 1'b1;
                seen[g] <= snext[g];
                wcnt[g] <= cur[g] + 1'b1;
                for (int i = 0; i < NL; i++)
                  if (hit[g][i] && !seen[g][i]) tarr[i] <= cur[g];
              end
            end
            S_MON:
              if (omis[g]) begin
                mis[g] <= 1'b1;
                if (dyn) begin
                  st[g] <= S_CNT; al[g] <= 1'b0; cnt[g] <= '0;
                end
              end
            default: st[g] <= S_IDLE;
          endcase
        end
      end
    end

  assign grp_aligned  = grp4 ? {2{al[0]}}  : al;
  assign grp_misalign = grp4 ? {2{mis[0]}} : mis;
  assign skew_err     = err;
endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
  parameter int DW = 8,
  parameter logic [7:0] MARKER = 8'h7C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          manual,
  input logic          grp4,
  input logic [4*DW-1:0] rx_data,
  input logic [3:0]    rx_ctrl,
  input logic [4*DW-1:0] tx_data,
  input logic [3:0]    tx_ctrl,
  input logic [1:0]    grp_aligned,
  input logic [1:0]    grp_misalign
);
  logic [3:0] omk;
  for (genvar i = 0; i < 4; i++) begin : g_mk
    assign omk[i] = tx_ctrl[i] && (tx_data[i*DW +: DW] == MARKER[DW-1:0]);
  end

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (tx_data == rx_data && tx_ctrl == rx_ctrl));

  p_status_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (grp_aligned == 2'b00 && grp_misalign == 2'b00));

  p_exit_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grp_aligned[0]) && $stable(grp4)) |-> (grp4 ? omk == 4'hF : omk[1:0] == 2'b11));

  p_pair_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grp_aligned[1]) && !grp4 && $stable(grp4)) |-> omk[3:2] == 2'b11);

  p_manual_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && manual) |=> grp_aligned == 2'b00);

  p_mis_from_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grp_misalign[0]) && $stable(grp4)) |-> $past(grp_aligned[0]));
endmodule

bind lane_deskew lane_deskew_chk #(.DW(DW), .MARKER(MARKER)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(r_ctrl[0]), .manual(r_mode[0]), .grp4(r_ctrl[1]),
  .rx_data(rx_data), .rx_ctrl(rx_ctrl), .tx_data(tx_data), .tx_ctrl(tx_ctrl),
  .grp_aligned(grp_aligned), .grp_misalign(grp_misalign));

// File: tb/test_lane_deskew.sv
`timescale 1ns/1ps
module test_lane_deskew;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [7:0] cfg_addr, cfg_wdata, cfg_rdata;
  logic cfg_we;
  logic [31:0] rx_data, tx_data;
  logic [3:0] rx_ctrl, rx_lock, tx_ctrl;
  logic [1:0] grp_aligned, grp_misalign;
  logic skew_err;

  lane_deskew i_lane_deskew (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_data(rx_data),
    .rx_ctrl(rx_ctrl), .rx_lock(rx_lock), .tx_data(tx_data), .tx_ctrl(tx_ctrl),
    .grp_aligned(grp_aligned), .grp_misalign(grp_misalign), .skew_err(skew_err));

  int total = 0, bad = 0;
  bit finished = 0;
  int ex [4];
  bit mis_seen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic clear_all();
    wr(8'h07, 8'h00); wr(8'h08, 8'h00); wr(8'h09, 8'h00); wr(8'h0A, 8'h00);
    rx_lock = 4'hF;
  endtask

  // markers at cycle off+2; ex[] gets the last output-marker cycle minus 2
  task automatic send_set(input int off [4], input bit flagless3 = 1'b0);
    for (int i = 0; i < 4; i++) ex[i] = -1;
    mis_seen = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (c == off[i] + 2) begin
          rx_data[i*8 +: 8] = 8'h7C;
          rx_ctrl[i] = !(flagless3 && i == 3);
        end else begin
          rx_data[i*8 +: 8] = 8'((c * 4 + i) | 8'h80);
          rx_ctrl[i] = 1'b0;
        end
      end
      #1;
      for (int i = 0; i < 4; i++)
        if (tx_ctrl[i] && tx_data[i*8 +: 8] == 8'h7C) ex[i] = c - 2;
      if (grp_misalign != 2'b00) mis_seen = 1'b1;
    end
  endtask

  task automatic chk_exits(input string req, input int e [4]);
    for (int i = 0; i < 4; i++) chk(ex[i] == e[i], req, ex[i], e[i]);
  endtask

  task automatic t_reset();
    int v;
    @(negedge clk);
    rx_data = 32'h1234_5678; rx_ctrl = 4'b1010;
    #1;
    chk(tx_data == 32'h1234_5678, "R2 reset passthrough", tx_data, 32'h1234_5678);
    chk(grp_aligned == 0 && grp_misalign == 0 && skew_err == 0, "R1 reset status", grp_aligned, 0);
    for (int a = 7; a <= 10; a++) begin
      rd(8'(a), v);
      chk(v == 0, "R1 reset value", v, 0);
    end
  endtask

  task automatic t_regs();
    int v;
    wr(8'h07, 8'hA4); wr(8'h08, 8'h3C); wr(8'h09, 8'h5A); wr(8'h0A, 8'hC3);
    rd(8'h07, v); chk(v == 8'hA4, "R1 readback 07h", v, 8'hA4);
    rd(8'h08, v); chk(v == 8'h3C, "R1 readback 08h", v, 8'h3C);
    rd(8'h09, v); chk(v == 8'h5A, "R1 readback 09h", v, 8'h5A);
    rd(8'h0A, v); chk(v == 8'hC3, "R1 readback 0Ah", v, 8'hC3);
    rd(8'h0B, v); chk(v == 0, "R1 unmapped", v, 0);
    clear_all();
  endtask

  task automatic t_bypass();  // R2
    wr(8'h07, 8'h0E);
    send_set('{0, 2, 5, 1});
    chk_exits("R2 bypass exits", '{0, 2, 5, 1});
    chk(grp_aligned == 0, "R2 no alignment while disabled", grp_aligned, 0);
    clear_all();
  endtask

  task automatic t_auto();  // R3
    wr(8'h07, 8'h03);
    send_set('{0, 2, 5, 1});
    chk_exits("R3 aligned exit", '{6, 6, 6, 6});
    chk(grp_aligned == 2'b11, "R3 aligned", grp_aligned, 3);
    send_set('{0, 0, 0, 0});
    chk_exits("R3 stored delays", '{6, 4, 1, 5});
    clear_all();
  endtask

  task automatic t_marker();  // R4
    wr(8'h07, 8'h03);
    send_set('{0, 0, 0, 0}, 1'b1);
    chk(grp_aligned == 0, "R4 flagless byte no marker", grp_aligned, 0);
    chk(skew_err == 1, "R4 incomplete set errors", skew_err, 1);
    clear_all();
  endtask

  task automatic t_trigger();  // R5
    wr(8'h07, 8'h0B);
    send_set('{1, 0, 2, 0});
    chk(grp_aligned == 0, "R5 after first set", grp_aligned, 0);
    chk_exits("R5 no delay after first set", '{1, 0, 2, 0});
    send_set('{1, 0, 2, 0});
    chk(grp_aligned == 0, "R5 after second set", grp_aligned, 0);
    send_set('{1, 0, 2, 0});
    chk(grp_aligned == 2'b11, "R5 after third set", grp_aligned, 3);
    chk_exits("R5 third set exit", '{3, 3, 3, 3});
    clear_all();
  endtask

  task automatic t_start();  // R6
    rx_lock = 4'b0001;
    wr(8'h07, 8'h43);
    send_set('{0, 1, 0, 0});
    chk(grp_aligned == 0, "R6 lane2 unlocked blocks", grp_aligned, 0);
    chk_exits("R6 no delay while waiting", '{0, 1, 0, 0});
    rx_lock = 4'b0100;
    send_set('{0, 1, 0, 0});
    chk(grp_aligned == 2'b11, "R6 lane2 locked starts", grp_aligned, 3);
    chk_exits("R6 exit", '{2, 2, 2, 2});
    clear_all();
  endtask

  task automatic t_pairs();  // R7
    wr(8'h07, 8'h01);
    send_set('{0, 3, 0, 7});
    chk_exits("R7 pair exits", '{4, 4, 8, 8});
    chk(grp_aligned == 2'b11, "R7 both pairs aligned", grp_aligned, 3);
    clear_all();
  endtask

  task automatic t_window();  // R8
    wr(8'h07, 8'h03);
    send_set('{0, 14, 0, 0});
    chk(grp_aligned == 2'b11, "R8 skew 14 aligns", grp_aligned, 3);
    chk_exits("R8 skew 14 exit", '{15, 15, 15, 15});
    wr(8'h08, 8'h01); wr(8'h08, 8'h00);
    wr(8'h07, 8'h07);
    send_set('{0, 15, 0, 0});
    chk(skew_err == 1, "R8 skew 15 error", skew_err, 1);
    chk(grp_aligned == 0, "R8 skew 15 not aligned", grp_aligned, 0);
    send_set('{0, 0, 0, 0});
    chk_exits("R8 delays kept", '{15, 1, 15, 15});
    clear_all();
  endtask

  task automatic t_manual();  // R9
    wr(8'h07, 8'h03); wr(8'h08, 8'h01); wr(8'h09, 8'h52); wr(8'h0A, 8'h0F);
    send_set('{0, 0, 0, 0});
    chk_exits("R9 manual exits", '{2, 5, 15, 0});
    chk(grp_aligned == 0, "R9 no aligned in manual", grp_aligned, 0);
    clear_all();
  endtask

  task automatic t_monitor();  // R10
    wr(8'h07, 8'h03);
    send_set('{0, 2, 5, 1});
    chk(mis_seen == 0, "R10 clean set no misalign", mis_seen, 0);
    send_set('{0, 0, 0, 0});
    chk(mis_seen == 1 && grp_misalign == 2'b11, "R10 misalign flagged", grp_misalign, 3);
    chk(grp_aligned == 2'b11, "R10 stays aligned", grp_aligned, 3);
    chk_exits("R10 delays unchanged", '{6, 4, 1, 5});
    clear_all();
  endtask

  task automatic t_realign();  // R11
    wr(8'h08, 8'h02); wr(8'h07, 8'h03);
    send_set('{0, 2, 5, 1});
    send_set('{0, 0, 0, 0});
    chk(mis_seen == 1, "R11 misalign seen", mis_seen, 1);
    chk(grp_aligned == 0, "R11 aligned dropped", grp_aligned, 0);
    send_set('{3, 0, 0, 0});
    chk(grp_aligned == 2'b11, "R11 realigned", grp_aligned, 3);
    chk(grp_misalign == 0, "R11 misalign cleared", grp_misalign, 0);
    chk_exits("R11 new delays", '{4, 4, 4, 4});
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_we = 1'b0;
    rx_data = '0; rx_ctrl = '0; rx_lock = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_bypass();
    t_auto();
    t_marker();
    t_trigger();
    t_start();
    t_pairs();
    t_window();
    t_manual();
    t_monitor();
    t_realign();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule